// File: doc/BRIEF.md
# Four-bit arithmetic and shift unit

This block is a purely combinational datapath slice. It takes two operands, a carry input and a three-bit select, and returns a result with a carry output in the same cycle. The top select bit picks between two sections. In the arithmetic section a ripple chain of full adders adds operand A to a conditioned copy of operand B. The conditioning is chosen by the low two select bits and can give all zeros, B itself, the bitwise complement of B or all ones. Together with the carry input, these four settings yield eight arithmetic operations: transfer, increment, add, add with carry, subtract with borrow, subtract, decrement and a second transfer.

In the shift section A is moved by exactly one bit position. A three-bit code chooses the shift. It is formed from the low two select bits with the carry input as its least significant bit. The available shifts are logical, arithmetic and circular, each to the left or to the right. The bit pushed out of A appears on the carry output. The remaining codes pass A through unchanged.

The unit holds no state. It is meant to sit inside a larger registered pipeline stage, where the surrounding logic decides when to capture its outputs.

Top module: `arith_shift_unit`

## Requirements
- R1: `sel[2]` = 0 selects the arithmetic section and `sel[2]` = 1 selects the shift section. In shift mode the shift code is {`sel[1]`, `sel[0]`, `carry_in`}. Both outputs depend only on the present inputs, with no clock and no stored state.
- R2: With `sel` = 3'b000, {`carry_out`, `result`} = A + `carry_in`. With `carry_in` = 0 this is a plain transfer of A, with `carry_out` = 0.
- R3: With `sel` = 3'b001, {`carry_out`, `result`} = A + B + `carry_in`, and `carry_out` is the carry leaving the most significant stage.
- R4: With `sel` = 3'b010, {`carry_out`, `result`} = A + ~B + `carry_in`. With `carry_in` = 1 the result is A − B, and `carry_out` = 1 exactly when A ≥ B (no borrow).
- R5: With `sel` = 3'b011, {`carry_out`, `result`} = A + all-ones + `carry_in`. With `carry_in` = 0 this gives A − 1, with `carry_out` = 0 only for A = 0. With `carry_in` = 1 it gives A, with `carry_out` = 1.
- R6: Shift codes 000 (logical) and 010 (arithmetic) shift A left by one. A zero enters the LSB and `carry_out` is the old MSB of A.
- R7: Shift code 001 is a logical right shift. A zero enters the MSB and `carry_out` is the old LSB of A.
- R8: Shift code 011 is an arithmetic right shift. The old MSB is copied into the MSB and `carry_out` is the old LSB of A.
- R9: Shift code 100 rotates A left and code 101 rotates A right. The bit that wraps around also appears on `carry_out`.
- R10: Shift codes 110 and 111 return A unchanged with `carry_out` = 0. In shift mode, operand B has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A; adder input and shift source |
| op_b | input | WIDTH | Operand B; conditioned before the adder |
| carry_in | input | 1 | Adder carry input; LSB of the shift code in shift mode |
| sel | input | 3 | Bit 2: section select; bits 1:0: B conditioning or shift code upper bits |
| result | output | WIDTH | Selected section's result |
| carry_out | output | 1 | Adder MSB carry, or the bit shifted out |

## Verification
The bench builds the unit with its default WIDTH of 4. At this width, every pair of operands can be applied under every one of the 16 select and carry combinations: 4096 vectors in all. This covers every carry-out boundary of the adder, every sign bit seen by the arithmetic right shift, and every wrap-around bit of the rotates. Random vectors with a fixed seed and directed checks add to this. The directed checks target the zero operand, the all-ones operand, and the rule that B is ignored in shift mode.

// File: rtl/asu_pkg.sv
// Package: shared types for the arithmetic and shift unit.
// Assumes a shift code formed as {sel[1], sel[0], carry_in}.
package asu_pkg;

    // B-side conditioning choices, encoded by sel[1:0].
    typedef enum logic [1:0] {
        BSIDE_ZERO = 2'b00,
        BSIDE_PASS = 2'b01,
        BSIDE_INV  = 2'b10,
        BSIDE_ONES = 2'b11
    } bside_e;

    // One-position shift choices, encoded by {sel[1:0], carry_in}.
    typedef enum logic [2:0] {
        SH_LSL  = 3'b000,
        SH_LSR  = 3'b001,
        SH_ASL  = 3'b010,
        SH_ASR  = 3'b011,
        SH_ROL  = 3'b100,
        SH_ROR  = 3'b101,
        SH_PASA = 3'b110,
        SH_PASB = 3'b111
    } shift_e;

endpackage

// File: rtl/asu_bside.sv
// Module: asu_bside
// Conditions operand B before it enters the adder: zeros, B, ~B or ones.
// Assumes a purely combinational path; no state.
module asu_bside #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] b_out
);
    import asu_pkg::*;

    // Select the conditioned B value from the two mode bits.
    always_comb begin
        case (bside_e'(mode))
            BSIDE_ZERO: b_out = '0;
            BSIDE_PASS: b_out = b_in;
            BSIDE_INV:  b_out = ~b_in;
            default:    b_out = '1;
        endcase
    end
endmodule

// File: rtl/asu_ripple.sv
// Module: asu_ripple
// Ripple-carry adder of WIDTH cascaded full adders.
// Carry enters bit 0; the carry output leaves the MSB stage.
module asu_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    // One full adder per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic prop;
        assign prop        = x[i] ^ y[i];
        assign sum[i]      = prop ^ chain[i];
        assign chain[i+1]  = (x[i] & y[i]) | (prop & chain[i]);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/asu_shift.sv
// Module: asu_shift
// One-position shifter: logical, arithmetic and circular, left and right.
// The bit moved out of the operand goes to shout; pass-through codes give 0.
// Assumes WIDTH >= 2.
module asu_shift #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [2:0]       code,
    output logic [WIDTH-1:0] res,
    output logic             shout
);
    import asu_pkg::*;

    localparam int MSB = WIDTH - 1;

    // Decode the shift code into result and shifted-out bit.
    always_comb begin
        case (shift_e'(code))
            SH_LSL, SH_ASL: begin
                res   = {a[MSB-1:0], 1'b0};
                shout = a[MSB];
            end
            SH_LSR: begin
                res   = {1'b0, a[MSB:1]};
                shout = a[0];
            end
            SH_ASR: begin
                res   = {a[MSB], a[MSB:1]};
                shout = a[0];
            end
            SH_ROL: begin
                res   = {a[MSB-1:0], a[MSB]};
                shout = a[MSB];
            end
            SH_ROR: begin
                res   = {a[0], a[MSB:1]};
                shout = a[0];
            end
            default: begin
                res   = a;
                shout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/arith_shift_unit.sv
// Module: arith_shift_unit
// Top of the combinational arithmetic and shift unit.
// sel[2] = 0: A plus conditioned B plus carry_in; sel[2] = 1: one-bit shift of A
// chosen by {sel[1:0], carry_in}. No clock, no reset, no state.
module arith_shift_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [2:0]       sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    logic [WIDTH-1:0] b_cond;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [WIDTH-1:0] sh_res;
    logic             sh_out;

    asu_bside #(.WIDTH(WIDTH)) u_bside (
        .b_in  (op_b),
        .mode  (sel[1:0]),
        .b_out (b_cond)
    );

    asu_ripple #(.WIDTH(WIDTH)) u_add (
        .x    (op_a),
        .y    (b_cond),
        .cin  (carry_in),
        .sum  (add_sum),
        .cout (add_cout)
    );

    asu_shift #(.WIDTH(WIDTH)) u_shift (
        .a     (op_a),
        .code  ({sel[1:0], carry_in}),
        .res   (sh_res),
        .shout (sh_out)
    );

    // Pick the active section's outputs.
    always_comb begin
        if (sel[2]) begin
            result    = sh_res;
            carry_out = sh_out;
        end else begin
            result    = add_sum;
            carry_out = add_cout;
        end
    end
endmodule

// File: rtl/asu_checker.sv
// Module: asu_checker
// Port-level properties of arith_shift_unit, bound to every instance.
// Combinational block, so immediate assertions on settled values.
module asu_checker #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [2:0]       sel,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic known;
    assign known = !$isunknown({op_a, op_b, carry_in, sel, result, carry_out});

    // Check each requirement that a property can express.
    always_comb begin
        if (known) begin
            if (sel == 3'b000 && !carry_in)
                a_r2_transfer: assert (result == op_a && !carry_out);
            if (sel == 3'b010 && carry_in)
                a_r4_subtract: assert (result == WIDTH'(op_a - op_b) && carry_out == (op_a >= op_b));
            if (sel[2] && !carry_in && sel[1:0] != 2'b11)
                a_r6_left_out: assert (carry_out == op_a[WIDTH-1] && result[WIDTH-1:1] == op_a[WIDTH-2:0]);
            if (sel == 3'b100 && carry_in)
                a_r7_zero_fill: assert (!result[WIDTH-1] && carry_out == op_a[0]);
            if (sel == 3'b101 && carry_in)
                a_r8_sign_keep: assert (result[WIDTH-1] == op_a[WIDTH-1] && carry_out == op_a[0]);
            if (sel == 3'b110)
                a_r9_rot_bits: assert ($countones(result) == $countones(op_a));
            if (sel == 3'b111)
                a_r10_pass: assert (result == op_a && !carry_out);
        end
    end
endmodule

bind arith_shift_unit asu_checker #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sel       (sel),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_arith_shift_unit.sv
// Bench: exhaustive, random and directed checks against a reference function.
module sim_arith_shift_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [2:0]   sel = '0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    arith_shift_unit #(.WIDTH(W)) u0 (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sel(sel),
        .result(result), .carry_out(carry_out)
    );

    always #5 clk = ~clk;

    // Expected {carry, result} from the requirements.
    function automatic logic [W:0] expect_of(logic [W-1:0] a, logic [W-1:0] b,
                                             logic c, logic [2:0] s);
        logic [W-1:0] bc;
        if (!s[2]) begin
            case (s[1:0])
                2'b00: bc = '0;
                2'b01: bc = b;
                2'b10: bc = ~b;
                default: bc = '1;
            endcase
            return {1'b0, a} + {1'b0, bc} + {{W{1'b0}}, c};
        end
        case ({s[1:0], c})
            3'b000, 3'b010: return {a[W-1], a[W-2:0], 1'b0};
            3'b001: return {a[0], 1'b0, a[W-1:1]};
            3'b011: return {a[0], a[W-1], a[W-1:1]};
            3'b100: return {a[W-1], a[W-2:0], a[W-1]};
            3'b101: return {a[0], a[0], a[W-1:1]};
            default: return {1'b0, a};
        endcase
    endfunction

    // Requirement tag covering a given select/carry combination.
    function automatic string req_of(logic [2:0] s, logic c);
        case ({s, c})
            4'b0000, 4'b0001: return "R2";
            4'b0010, 4'b0011: return "R3";
            4'b0100, 4'b0101: return "R4";
            4'b0110, 4'b0111: return "R5";
            4'b1000, 4'b1010: return "R6";
            4'b1001: return "R7";
            4'b1011: return "R8";
            4'b1100, 4'b1101: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Drive inputs after a falling edge, sample two time units later.
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c, logic [2:0] s,
                         string tag);
        logic [W:0] exp_v;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c; sel = s;
        #2;
        exp_v = expect_of(a, b, c, s);
        checks++;
        if ({carry_out, result} !== exp_v) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b sel=%b: got %b_%h expected %b_%h",
                     tag, a, b, c, s, carry_out, result, exp_v[W], exp_v[W-1:0]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        int unsigned seed_word;
        logic [W-1:0] r_b1, r_b2;
        seed_word = $urandom(32'h5EED_0042);

        // Zero inputs under reset: R2 transfer of zero.
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result !== '0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle state: got %b_%h expected 0_0", carry_out, result);
        end
        rst_n = 1'b1;

        // Directed corners.
        apply(4'hF, 4'h0, 1'b1, 3'b000, "R2");   // increment wraps, carry 1
        apply(4'hF, 4'h1, 1'b0, 3'b001, "R3");   // add overflow
        apply(4'h3, 4'h3, 1'b1, 3'b010, "R4");   // A==B, no borrow
        apply(4'h2, 4'h5, 1'b1, 3'b010, "R4");   // A<B, borrow
        apply(4'h0, 4'h9, 1'b0, 3'b011, "R5");   // decrement of zero
        apply(4'h8, 4'h0, 1'b0, 3'b100, "R6");   // MSB out on left shift
        apply(4'h9, 4'h0, 1'b1, 3'b100, "R7");   // zero fill right
        apply(4'hA, 4'h0, 1'b1, 3'b101, "R8");   // sign copied
        apply(4'h9, 4'h0, 1'b0, 3'b110, "R9");   // rotate left wraps MSB
        apply(4'h1, 4'h0, 1'b1, 3'b110, "R9");   // rotate right wraps LSB
        apply(4'h6, 4'h0, 1'b0, 3'b111, "R10");

        // R10: B must not affect any shift-mode output.
        for (int k = 0; k < 8; k++) begin
            r_b1 = W'($urandom());
            r_b2 = ~r_b1;
            apply(4'hB, r_b1, k[0], {1'b1, k[2:1]}, "R10");
            apply(4'hB, r_b2, k[0], {1'b1, k[2:1]}, "R10");
        end

        // Exhaustive sweep: every operand pair under every select/carry (R1).
        for (int s = 0; s < 16; s++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    apply(W'(a), W'(b), s[0], s[3:1], req_of(s[3:1], s[0]));
                end
            end
        end

        // Constrained random mix, shift mode weighted a bit higher.
        for (int n = 0; n < 400; n++) begin
            logic [2:0] rs;
            logic       rc;
            rs = 3'($urandom());
            if (n % 3 == 0) rs[2] = 1'b1;
            rc = 1'($urandom());
            apply(W'($urandom()), W'($urandom()), rc, rs, req_of(rs, rc));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule